// File: doc/BRIEF.md
# DMA Task Scheduler

This block decides which of sixteen DMA tasks owns the transfer engine. Each task has an enable bit and a 3-bit task priority. Each of sixteen request initiators has a 3-bit initiator priority and a 4-bit field naming the task it serves. A mode bit, written through a 16-bit control word, selects the arbitration scheme. In initiator-priority mode the task behind the strongest asserted initiator wins. In task-priority mode the enabled, requested task with the highest task priority wins. Ties always go to the higher task number.

The engine around the scheduler reports descriptor and loop-iteration boundaries through `boundary` and the end of a task's loop through `loop_done`. The scheduler uses these to decide whether the running task continues, is released, or is preempted. A preemption saves the outgoing task's context through a req/ack handshake and then restores the incoming one. Only after the restore is acknowledged does `task_running` go high. A task that was released rather than preempted is not saved. Request, enable, priority and mapping inputs are registered once, so they reach the arbitration one cycle after they are driven.

Top module: `dma_task_sched`

## Requirements
- R1: In initiator mode (mode bit 0), the winner is the enabled task whose mapped asserted initiator has the greatest initiator priority. Priority 7 is the highest and 0 the lowest. Initiator i's task number is `init_task[4i+3:4i]` and its priority is `init_prio[3i+2:3i]`.
- R2: In task mode (mode bit 1), the winner is the enabled task with at least one asserted mapped initiator and the greatest task priority `task_prio[3t+2:3t]`.
- R3: When several candidates share the top priority, the highest-numbered task wins.
- R4: A write with `ctrl_we` high loads bit 15 of `ctrl_wdata` as the mode bit, and the other fifteen bits have no effect. Reset clears the mode bit to 0 (initiator mode).
- R5: While `boundary` is low, a running task keeps running and `active_task` does not change, whatever the requests do.
- R6: At a boundary, the running task is preempted only when the winner's priority is strictly greater than the running task's own current priority. Equal priority never displaces it, even from a higher task number.
- R7: On preemption, `save_req` pulses for one cycle in the cycle after the boundary, with `save_task` equal to the outgoing task. After `save_ack`, `restore_req` pulses with `restore_task` equal to the winner.
- R8: `task_running` stays low while a restore is pending. It rises only in the cycle after `restore_ack` is sampled high, and `active_task` then shows the restored task.
- R9: At a boundary where `loop_done` is high, or where the running task has no asserted enabled initiator left, the task is released without `save_req`. The new winner is restored directly, or the block goes idle.
- R10: With no candidate, the block is idle with `task_running` and `active_valid` low. From idle, a restore of the winner starts as soon as a candidate is visible, without waiting for a boundary.
- R11: After reset, `save_req`, `restore_req`, `task_running` and `active_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word; bit 15 is the mode bit |
| task_en | input | 16 | Per-task enable |
| task_prio | input | 48 | Per-task priority, 3 bits per task |
| init_req | input | 16 | Initiator request lines |
| init_prio | input | 48 | Per-initiator priority, 3 bits each |
| init_task | input | 64 | Task number served by each initiator, 4 bits each |
| boundary | input | 1 | Descriptor or loop-iteration boundary |
| loop_done | input | 1 | Running task's loop finished (read with boundary) |
| save_ack | input | 1 | Context save finished |
| restore_ack | input | 1 | Context restore finished |
| save_req | output | 1 | One-cycle context save request |
| save_task | output | 4 | Task being saved |
| restore_req | output | 1 | One-cycle context restore request |
| restore_task | output | 4 | Task being restored |
| task_running | output | 1 | A restored task owns the engine |
| active_valid | output | 1 | `active_task` is meaningful |
| active_task | output | 4 | Running task number, 0 when none |

## Verification
The checker watches four things on every cycle. It checks that a running task never changes or stops between boundaries. It checks that a save request follows a boundary taken while running and names the outgoing task. It checks that save and restore strobes never coincide. It checks that `task_running` stays low during a restore and rises only after an acknowledge. The choice of winner cannot be seen from a single cycle, and neither can the strict-greater preemption rule or the difference between release and preemption. The bench's scenarios cover these through arbitration cases in both modes, ties, disabled tasks, equal-priority competitors, loop completion and dropped requests.

// File: rtl/dma_sched_pkg.sv
// Shared definitions for the DMA task scheduler.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dma_sched_pkg;

    // Scheduler sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SAVE = 2'd2,
        ST_LOAD = 2'd3
    } sched_state_e;

    // Position of the arbitration mode bit in the control word.
    localparam int MODE_BIT = 15;

endpackage

// File: rtl/dma_sched_inreg.sv
// Input stage: registers requests, enables, priorities and mapping, and
// holds the mode bit loaded from the control word.
// Assumes: inputs are synchronous to clk; reset is synchronous, active-low.
module dma_sched_inreg #(
    parameter int NT = 16,
    parameter int NI = 16,
    parameter int PW = 3,
    parameter int TW = 4,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CW-1:0]    ctrl_wdata,
    input  logic [NT-1:0]    task_en,
    input  logic [NT*PW-1:0] task_prio,
    input  logic [NI-1:0]    init_req,
    input  logic [NI*PW-1:0] init_prio,
    input  logic [NI*TW-1:0] init_task,
    output logic             mode_q,
    output logic [NT-1:0]    task_en_q,
    output logic [NT*PW-1:0] task_prio_q,
    output logic [NI-1:0]    init_req_q,
    output logic [NI*PW-1:0] init_prio_q,
    output logic [NI*TW-1:0] init_task_q
);
    import dma_sched_pkg::*;

    // Only the mode bit is kept; the rest of the word is dropped.
    logic unused_ctrl;
    assign unused_ctrl = ^ctrl_wdata;

    // Mode bit register, initiator mode after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 1'b0;
        else if (ctrl_we) mode_q <= ctrl_wdata[MODE_BIT];
    end

    // Request and configuration capture, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            task_en_q   <= '0;
            task_prio_q <= '0;
            init_req_q  <= '0;
            init_prio_q <= '0;
            init_task_q <= '0;
        end else begin
            task_en_q   <= task_en;
            task_prio_q <= task_prio;
            init_req_q  <= init_req;
            init_prio_q <= init_prio;
            init_task_q <= init_task;
        end
    end

endmodule

// File: rtl/dma_sched_arb.sv
// Combinational arbiter: forms a per-task candidate flag and priority,
// picks the winner (ties to the highest task number), and reports the
// current standing of a selected task.
// Assumes: inputs come from registers; NT is a power of two of 2**TW.
module dma_sched_arb #(
    parameter int NT = 16,
    parameter int NI = 16,
    parameter int PW = 3,
    parameter int TW = 4
) (
    input  logic             mode,
    input  logic [NT-1:0]    task_en,
    input  logic [NT*PW-1:0] task_prio,
    input  logic [NI-1:0]    init_req,
    input  logic [NI*PW-1:0] init_prio,
    input  logic [NI*TW-1:0] init_task,
    input  logic [TW-1:0]    sel_task,
    output logic             win_valid,
    output logic [TW-1:0]    win_task,
    output logic [PW-1:0]    win_prio,
    output logic             sel_valid,
    output logic [PW-1:0]    sel_prio
);
    logic [NT-1:0] cand_v;
    logic [PW-1:0] cand_p [NT];

    for (genvar t = 0; t < NT; t++) begin : g_task
        logic          hit;
        logic [PW-1:0] best;

        // Strongest asserted initiator mapped to this task.
        always_comb begin
            hit  = 1'b0;
            best = '0;
            for (int i = 0; i < NI; i++) begin
                if (init_req[i] && (init_task[i*TW +: TW] == TW'(t))) begin
                    hit = 1'b1;
                    if (init_prio[i*PW +: PW] > best) best = init_prio[i*PW +: PW];
                end
            end
        end

        // Candidate flag and the priority that counts in the current mode.
        always_comb begin
            cand_v[t] = hit && task_en[t];
            cand_p[t] = mode ? task_prio[t*PW +: PW] : best;
        end
    end

    // Linear scan upward; >= lets higher task numbers win ties.
    always_comb begin
        win_valid = 1'b0;
        win_task  = '0;
        win_prio  = '0;
        for (int t = 0; t < NT; t++) begin
            if (cand_v[t] && (!win_valid || (cand_p[t] >= win_prio))) begin
                win_valid = 1'b1;
                win_task  = TW'(t);
                win_prio  = cand_p[t];
            end
        end
    end

    // Standing of the selected (running) task.
    always_comb begin
        sel_valid = cand_v[sel_task];
        sel_prio  = cand_p[sel_task];
    end

endmodule

// File: rtl/dma_sched_fsm.sv
// Sequencer: keeps the running task, decides at boundaries between
// continue, release and preemption, and drives save/restore handshakes.
// Assumes: boundary/loop_done are single-cycle indications from the engine;
// acks may arrive in the same cycle as the matching request pulse or later.
module dma_sched_fsm #(
    parameter int PW = 3,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          loop_done,
    input  logic          save_ack,
    input  logic          restore_ack,
    input  logic          win_valid,
    input  logic [TW-1:0] win_task,
    input  logic [PW-1:0] win_prio,
    input  logic          sel_valid,
    input  logic [PW-1:0] sel_prio,
    output logic [TW-1:0] cur_task,
    output logic [TW-1:0] next_task,
    output logic          save_req,
    output logic          restore_req,
    output logic          running
);
    import dma_sched_pkg::*;

    sched_state_e state;

    // State sequencing with one-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur_task    <= '0;
            next_task   <= '0;
            save_req    <= 1'b0;
            restore_req <= 1'b0;
        end else begin
            save_req    <= 1'b0;
            restore_req <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (win_valid) begin
                        next_task   <= win_task;
                        restore_req <= 1'b1;
                        state       <= ST_LOAD;
                    end
                end
                ST_RUN: begin
                    if (boundary) begin
                        if (loop_done || !sel_valid) begin
                            if (win_valid) begin
                                next_task   <= win_task;
                                restore_req <= 1'b1;
                                state       <= ST_LOAD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (win_valid && (win_prio > sel_prio)) begin
                            next_task <= win_task;
                            save_req  <= 1'b1;
                            state     <= ST_SAVE;
                        end
                    end
                end
                ST_SAVE: begin
                    if (save_ack) begin
                        restore_req <= 1'b1;
                        state       <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (restore_ack) begin
                        cur_task <= next_task;
                        state    <= ST_RUN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Running flag decoded from state.
    always_comb running = (state == ST_RUN);

endmodule

// File: rtl/dma_task_sched.sv
// Top of the DMA task scheduler: input stage, arbiter and sequencer.
// Assumes: synchronous active-low reset; all inputs in the clk domain.
module dma_task_sched #(
    parameter int NT = 16,
    parameter int NI = 16,
    parameter int PW = 3,
    parameter int CW = 16,
    localparam int TW = $clog2(NT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CW-1:0]    ctrl_wdata,
    input  logic [NT-1:0]    task_en,
    input  logic [NT*PW-1:0] task_prio,
    input  logic [NI-1:0]    init_req,
    input  logic [NI*PW-1:0] init_prio,
    input  logic [NI*TW-1:0] init_task,
    input  logic             boundary,
    input  logic             loop_done,
    input  logic             save_ack,
    input  logic             restore_ack,
    output logic             save_req,
    output logic [TW-1:0]    save_task,
    output logic             restore_req,
    output logic [TW-1:0]    restore_task,
    output logic             task_running,
    output logic             active_valid,
    output logic [TW-1:0]    active_task
);
    logic             mode_q;
    logic [NT-1:0]    task_en_q;
    logic [NT*PW-1:0] task_prio_q;
    logic [NI-1:0]    init_req_q;
    logic [NI*PW-1:0] init_prio_q;
    logic [NI*TW-1:0] init_task_q;
    logic             win_valid, sel_valid, running;
    logic [TW-1:0]    win_task, cur_task, next_task;
    logic [PW-1:0]    win_prio, sel_prio;

    dma_sched_inreg #(.NT(NT), .NI(NI), .PW(PW), .TW(TW), .CW(CW)) u_inreg (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .task_en(task_en), .task_prio(task_prio), .init_req(init_req),
        .init_prio(init_prio), .init_task(init_task),
        .mode_q(mode_q), .task_en_q(task_en_q), .task_prio_q(task_prio_q),
        .init_req_q(init_req_q), .init_prio_q(init_prio_q), .init_task_q(init_task_q)
    );

    dma_sched_arb #(.NT(NT), .NI(NI), .PW(PW), .TW(TW)) u_arb (
        .mode(mode_q), .task_en(task_en_q), .task_prio(task_prio_q),
        .init_req(init_req_q), .init_prio(init_prio_q), .init_task(init_task_q),
        .sel_task(cur_task), .win_valid(win_valid), .win_task(win_task),
        .win_prio(win_prio), .sel_valid(sel_valid), .sel_prio(sel_prio)
    );

    dma_sched_fsm #(.PW(PW), .TW(TW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .loop_done(loop_done),
        .save_ack(save_ack), .restore_ack(restore_ack),
        .win_valid(win_valid), .win_task(win_task), .win_prio(win_prio),
        .sel_valid(sel_valid), .sel_prio(sel_prio),
        .cur_task(cur_task), .next_task(next_task),
        .save_req(save_req), .restore_req(restore_req), .running(running)
    );

    // Output mapping; the active number reads 0 when nothing runs.
    always_comb begin
        save_task    = cur_task;
        restore_task = next_task;
        task_running = running;
        active_valid = running;
        active_task  = running ? cur_task : '0;
    end

endmodule

// File: rtl/dma_task_sched_chk.sv
// Cycle-by-cycle properties of the scheduler's port behaviour.
// Assumes: bound to dma_task_sched with its default widths.
module dma_task_sched_chk #(
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          boundary,
    input logic          restore_ack,
    input logic          save_req,
    input logic [TW-1:0] save_task,
    input logic          restore_req,
    input logic          task_running,
    input logic [TW-1:0] active_task
);
    // R5
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (task_running && !boundary) |=> (task_running && $stable(active_task)));

    // R7
    save_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |-> ($past(task_running) && $past(boundary)));

    // R7
    save_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |-> (save_task == $past(active_task)));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req, restore_req}));

    // R8
    start_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(task_running) |-> $past(restore_ack));

    // R8
    restore_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> !task_running);

endmodule

bind dma_task_sched dma_task_sched_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .restore_ack(restore_ack),
    .save_req(save_req), .save_task(save_task), .restore_req(restore_req),
    .task_running(task_running), .active_task(active_task)
);

// File: tb/dma_task_sched_bench.sv
// Bench: fixed mapping (initiator i serves task 15-i, initiator priority
// i%8, task priority (3t)%8), a table of arbitration cases from idle, then
// directed tests of reset, mode, preemption, release and idle.
module dma_task_sched_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [15:0] task_en = '1;
    logic [47:0] task_prio;
    logic [15:0] init_req = '0;
    logic [47:0] init_prio;
    logic [63:0] init_task;
    logic        boundary = 1'b0, loop_done = 1'b0, save_ack = 1'b0, restore_ack = 1'b0;
    logic        save_req, restore_req, task_running, active_valid;
    logic [3:0]  save_task, restore_task, active_task;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dma_task_sched u_dma_task_sched (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .task_en(task_en), .task_prio(task_prio), .init_req(init_req),
        .init_prio(init_prio), .init_task(init_task), .boundary(boundary),
        .loop_done(loop_done), .save_ack(save_ack), .restore_ack(restore_ack),
        .save_req(save_req), .save_task(save_task), .restore_req(restore_req),
        .restore_task(restore_task), .task_running(task_running),
        .active_valid(active_valid), .active_task(active_task)
    );

    typedef struct packed {
        logic        mode;
        logic [15:0] en;
        logic [15:0] req;
        logic        ev;
        logic [3:0]  et;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'hFFFF, 16'h0001, 1'b1, 4'd15},  // R1 single initiator
        '{1'b0, 16'hFFFF, 16'h0088, 1'b1, 4'd8},   // R1 prio 7 beats 3
        '{1'b0, 16'hFFFF, 16'h8080, 1'b1, 4'd8},   // R3 tie 8 vs 0
        '{1'b1, 16'hFFFF, 16'h0404, 1'b1, 4'd13},  // R3 task tie 13 vs 5
        '{1'b0, 16'hFFFF, 16'h0210, 1'b1, 4'd11},  // R1 init prio 4 vs 1
        '{1'b1, 16'hFFFF, 16'h0210, 1'b1, 4'd6},   // R2 task prio 2 vs 1
        '{1'b0, 16'hF7FF, 16'h0210, 1'b1, 4'd6},   // R1 task 11 disabled
        '{1'b0, 16'h0000, 16'hFFFF, 1'b0, 4'd0},   // R10 nothing enabled
        '{1'b1, 16'hFFFF, 16'h3000, 1'b1, 4'd2}    // R2 task prio 6 vs 1
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait up to 8 cycles for a restore strobe; returns with clk low.
    task automatic await_restore(output bit seen, output logic [3:0] t);
        seen = 1'b0;
        t = '0;
        for (int k = 0; k < 8; k++) begin
            if (!seen) begin
                if (restore_req) begin
                    seen = 1'b1;
                    t = restore_task;
                end else begin
                    @(negedge clk);
                end
            end
        end
    endtask

    task automatic ack_restore();
        restore_ack = 1'b1;
        @(negedge clk);
        restore_ack = 1'b0;
    endtask

    task automatic pulse_boundary(input logic ld);
        boundary = 1'b1;
        loop_done = ld;
        @(negedge clk);
        boundary = 1'b0;
        loop_done = 1'b0;
    endtask

    task automatic write_ctrl(input logic [15:0] w);
        ctrl_we = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // Count strobes over n cycles.
    task automatic watch_quiet(input int n, output int strobes);
        strobes = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (save_req || restore_req) strobes++;
        end
    endtask

    task automatic to_idle();
        init_req = '0;
        task_en = '1;
        nclk(2);
        pulse_boundary(1'b0);
        nclk(2);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        bit seen;
        logic [3:0] t;
        int q;
        for (int i = 0; i < 16; i++) begin
            task_prio[i*3 +: 3] = 3'((i * 3) % 8);
            init_prio[i*3 +: 3] = 3'(i % 8);
            init_task[i*4 +: 4] = 4'(15 - i);
        end
        nclk(3);
        rst_n = 1'b1;
        nclk(1);

        // R11 reset state
        chk(!save_req && !restore_req, "R11 strobes after reset", int'({save_req, restore_req}), 0);
        chk(!task_running && !active_valid, "R11 running after reset", int'({task_running, active_valid}), 0);

        // R4 reset leaves initiator mode: init4 (task11, p4) beats init9 (task6, p1)
        init_req = 16'h0210;
        await_restore(seen, t);
        chk(seen && t == 4'd11, "R4 reset mode", int'(t), 11);
        ack_restore();
        to_idle();

        // R4 only bit 15 matters
        write_ctrl(16'h7FFF);
        init_req = 16'h0210;
        await_restore(seen, t);
        chk(seen && t == 4'd11, "R4 low bits ignored", int'(t), 11);
        ack_restore();
        to_idle();

        // Table walk: R1 R2 R3 R10
        for (int v = 0; v < NV; v++) begin
            write_ctrl(VEC[v].mode ? 16'h8000 : 16'h0000);
            task_en = VEC[v].en;
            init_req = VEC[v].req;
            await_restore(seen, t);
            if (VEC[v].ev) begin
                chk(seen && t == VEC[v].et, "R1/R2/R3 table winner", int'(t), int'(VEC[v].et));
                ack_restore();
                chk(task_running && active_valid && active_task == VEC[v].et,
                    "R8 table running", int'(active_task), int'(VEC[v].et));
            end else begin
                chk(!seen && !task_running, "R10 table no candidate", int'(seen), 0);
            end
            to_idle();
        end

        // Preemption in initiator mode
        write_ctrl(16'h0000);
        init_req = 16'h0010;               // init4 -> task11 p4
        await_restore(seen, t);
        chk(seen && t == 4'd11, "R10 start from idle", int'(t), 11);
        chk(!task_running, "R8 low before ack", int'(task_running), 0);
        ack_restore();
        chk(task_running && active_task == 4'd11, "R8 running after ack", int'(active_task), 11);
        init_req = 16'h0090;               // add init7 -> task8 p7
        watch_quiet(5, q);
        chk(q == 0 && active_task == 4'd11, "R5 no switch without boundary", q, 0);
        pulse_boundary(1'b0);
        chk(save_req && save_task == 4'd11, "R7 save outgoing", int'(save_task), 11);
        chk(!task_running, "R7 stopped while saving", int'(task_running), 0);
        save_ack = 1'b1;
        @(negedge clk);
        save_ack = 1'b0;
        await_restore(seen, t);
        chk(seen && t == 4'd8, "R7 restore incoming", int'(t), 8);
        ack_restore();
        chk(task_running && active_task == 4'd8, "R7 preempted to 8", int'(active_task), 8);
        to_idle();

        // Equal priority in task mode: task4 (p4) running, task12 (p4) arrives
        write_ctrl(16'h8000);
        init_req = 16'h0800;               // init11 -> task4
        await_restore(seen, t);
        chk(seen && t == 4'd4, "R2 start task4", int'(t), 4);
        ack_restore();
        init_req = 16'h0808;               // add init3 -> task12
        nclk(2);
        pulse_boundary(1'b0);
        watch_quiet(4, q);
        chk(q == 0 && active_task == 4'd4, "R6 equal priority keeps", int'(active_task), 4);

        // Loop done: release, no save, tie goes to 12
        pulse_boundary(1'b1);
        chk(!save_req, "R9 no save on loop done", int'(save_req), 0);
        await_restore(seen, t);
        chk(seen && t == 4'd12, "R9 restore after loop done", int'(t), 12);
        ack_restore();
        chk(active_task == 4'd12, "R9 running 12", int'(active_task), 12);

        // Initiator dropped: release to task4 without save
        init_req = 16'h0800;
        nclk(2);
        pulse_boundary(1'b0);
        chk(!save_req, "R9 no save on drop", int'(save_req), 0);
        await_restore(seen, t);
        chk(seen && t == 4'd4, "R9 restore after drop", int'(t), 4);
        ack_restore();

        // Everything dropped: idle
        init_req = '0;
        nclk(2);
        pulse_boundary(1'b0);
        watch_quiet(3, q);
        chk(q == 0 && !task_running && !active_valid, "R10 idle",
            int'({task_running, active_valid}), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule